// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block turns single requests from a synchronous port into timed access cycles on an external asynchronous 16-bit static RAM. The RAM has active-low controls: chip select, output enable, write enable, and one strobe for each byte lane. A request carries a read/write flag, an address, write data and one enable bit for each byte lane. The controller splits each access into phases that last a whole number of clock cycles. Each phase length is worked out at elaboration time from the RAM's minimum timings in nanoseconds and from the clock period, always rounding up. The default settings assume a 10 ns clock.

The request side follows valid/ready rules. The requester holds `req_valid` and its fields steady until it sees `req_ready` high at a rising edge, and the request is taken at that edge. Ready is high only while the controller is idle, so every access applies back-pressure until it has finished. Reads end with a one-cycle `rsp_valid` pulse. This channel has no ready signal: the requester must always take a response. The bidirectional data bus is split into three signals: an output value, an input value and a drive enable. The controller only drives the bus when the RAM output is sure to be high-impedance.

Top module: `sram_ctl`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is taken on a rising edge where `req_valid` and `req_ready` are both high, and `req_ready` is low in the cycle after that edge. Each request taken produces at most one access and at most one response.
- R2: A read with at least one lane enabled holds chip select and output enable low for RD_CYC cycles (2 by default). The data bus is sampled at the end of the last of these cycles. `rsp_valid` is high for exactly one cycle, starting RD_CYC edges after the accepting edge.
- R3: Read data is returned as a full word. Bits 15:8 belong to lane 1 and bits 7:0 belong to lane 0. A lane whose enable bit is 0 reads back as zero, whatever the bus carries.
- R4: During a write, output enable stays high for the whole access. Chip select, the address and the byte strobes are set AS_CYC cycles (1 by default) before write enable goes low.
- R5: Write enable stays low for WP_CYC consecutive cycles (1 by default). The data-bus drive enable is high exactly while write enable is low, so the data is stable for the whole pulse and is released on the edge where write enable rises.
- R6: The drive enable never rises while output enable is low, and never rises in the cycle right after output enable was low.
- R7: While chip select is low, each byte strobe is low exactly when the enable bit of its lane is 1 (`sram_bs_n[1]` is the upper byte). While chip select is high, all strobes are high.
- R8: A request with both lane enables at 0 never asserts chip select or write enable, and leaves the memory unchanged. For a read, it returns zero with `rsp_valid` high in the cycle right after the accepting edge.
- R9: Between two accesses, chip select stays high for at least two cycles: one recovery cycle and the idle cycle in which the next request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 1 = upper byte |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| sram_addr | output | 16 | RAM address |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_bs_n | output | 2 | RAM byte strobes, active low, bit 1 = upper |
| sram_dq_out | output | 16 | Value to drive onto the data bus |
| sram_dq_in | input | 16 | Value read from the data bus |
| sram_dq_oe | output | 1 | Data-bus drive enable |

## Verification
Two things can fall in the same cycle. The first is a write whose drive enable is about to rise. The second is a read that ended just before it, whose RAM output may still be leaving the bus. The bench provokes this by issuing a write immediately after a read, both full-word and byte-only. A RAM model in the bench counts any cycle in which the controller drives the bus while output enable is low, and any write pulse whose data was not driven. The read response that follows must then match a shadow memory.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_ASET,
    ST_WPUL,
    ST_REC
  } phase_e;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // cycles still needed after 'used' have passed, never fewer than one
  function automatic int rest1(input int total, input int used);
    return (total > used) ? (total - used) : 1;
  endfunction

endpackage

// File: rtl/sram_ctl_phase_cnt.sv
module sram_ctl_phase_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == '0);

endmodule

// File: rtl/sram_ctl_lane_mask.sv
module sram_ctl_lane_mask #(
  parameter int LANES = 2
) (
  input  logic [LANES*8-1:0] din,
  input  logic [LANES-1:0]   en,
  output logic [LANES*8-1:0] dout
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign dout[i*8 +: 8] = en[i] ? din[i*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int CLK_NS  = 10,
  parameter int T_RC_NS = 10,
  parameter int T_AA_NS = 10,
  parameter int T_WC_NS = 10,
  parameter int T_CW_NS = 7,
  parameter int T_WP_NS = 7,
  parameter int T_DW_NS = 5,
  parameter int T_HZ_NS = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_be,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0]     sram_addr,
  output logic                  sram_cs_n,
  output logic                  sram_oe_n,
  output logic                  sram_we_n,
  output logic [DATA_W/8-1:0]   sram_bs_n,
  output logic [DATA_W-1:0]     sram_dq_out,
  input  logic [DATA_W-1:0]     sram_dq_in,
  output logic                  sram_dq_oe
);

  localparam int LANES   = DATA_W / 8;
  // read: access time must elapse before the sampling edge, plus full cycle time
  localparam int RD_CYC  = imax(cdiv(T_AA_NS, CLK_NS) + 1, cdiv(T_RC_NS, CLK_NS));
  // address setup doubles as bus turnaround after a read
  localparam int AS_CYC  = imax(1, cdiv(T_HZ_NS, CLK_NS));
  localparam int WP_CYC  = imax(imax(cdiv(T_WP_NS, CLK_NS), cdiv(T_DW_NS, CLK_NS)),
                                imax(rest1(cdiv(T_WC_NS, CLK_NS), AS_CYC),
                                     rest1(cdiv(T_CW_NS, CLK_NS), AS_CYC)));
  localparam int CNT_MAX = imax(RD_CYC, imax(AS_CYC, WP_CYC));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  phase_e             state, state_nxt;
  logic               cnt_load;
  logic [CNT_W-1:0]   cnt_val;
  logic               phase_last;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [LANES-1:0]   be_q;
  logic [DATA_W-1:0]  rd_masked;
  logic               active;
  logic               take;

  assign req_ready = (state == ST_IDLE);
  assign take      = req_valid && req_ready;

  sram_ctl_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .last     (phase_last)
  );

  sram_ctl_lane_mask #(.LANES(LANES)) u_mask (
    .din  (sram_dq_in),
    .en   (be_q),
    .dout (rd_masked)
  );

  always_comb begin
    state_nxt = state;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_be == '0) begin
            state_nxt = ST_REC;
          end else if (req_write) begin
            state_nxt = ST_ASET;
            cnt_load  = 1'b1;
            cnt_val   = CNT_W'(AS_CYC - 1);
          end else begin
            state_nxt = ST_READ;
            cnt_load  = 1'b1;
            cnt_val   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_READ: if (phase_last) state_nxt = ST_REC;
      ST_ASET: begin
        if (phase_last) begin
          state_nxt = ST_WPUL;
          cnt_load  = 1'b1;
          cnt_val   = CNT_W'(WP_CYC - 1);
        end
      end
      ST_WPUL: if (phase_last) state_nxt = ST_REC;
      ST_REC:  state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state     <= state_nxt;
      rsp_valid <= 1'b0;
      if (take) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
        if (!req_write && req_be == '0) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= '0;
        end
      end
      if (state == ST_READ && phase_last) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_masked;
      end
    end
  end

  assign active      = (state == ST_READ) || (state == ST_ASET) || (state == ST_WPUL);
  assign sram_addr   = addr_q;
  assign sram_cs_n   = !active;
  assign sram_oe_n   = (state != ST_READ);
  assign sram_we_n   = (state != ST_WPUL);
  assign sram_bs_n   = ~({LANES{active}} & be_q);
  assign sram_dq_out = wdata_q;
  assign sram_dq_oe  = (state == ST_WPUL);

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int LANES  = 2,
  parameter int MIN_WP = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LANES-1:0] req_be,
  input logic             rsp_valid,
  input logic             sram_cs_n,
  input logic             sram_oe_n,
  input logic             sram_we_n,
  input logic [LANES-1:0] sram_bs_n,
  input logic             sram_dq_oe
);

  logic [7:0] we_low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
    end else if (!sram_we_n) begin
      if (we_low_cnt != 8'hFF) we_low_cnt <= we_low_cnt + 1'b1;
    end else begin
      we_low_cnt <= '0;
    end
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_cs_n |-> !req_ready); // R1

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R2

  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n && !sram_cs_n)); // R4

  AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> !sram_we_n); // R5

  AST_WE_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (int'(we_low_cnt) >= MIN_WP)); // R5

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (sram_oe_n && $past(sram_oe_n))); // R6

  AST_STROBES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sram_cs_n |-> (&sram_bs_n)); // R7

  AST_STROBES_SOME: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_cs_n |-> !(&sram_bs_n)); // R7

  AST_ZERO_BE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_be == '0) |=> (sram_cs_n && sram_we_n)); // R8

  AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_cs_n) |=> sram_cs_n); // R9

endmodule

bind sram_ctl sram_ctl_chk #(.LANES(LANES), .MIN_WP(WP_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_be     (req_be),
  .rsp_valid  (rsp_valid),
  .sram_cs_n  (sram_cs_n),
  .sram_oe_n  (sram_oe_n),
  .sram_we_n  (sram_we_n),
  .sram_bs_n  (sram_bs_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RD_EXP     = 2;
  localparam int WP_EXP     = 1;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [15:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] sram_addr;
  logic        sram_cs_n;
  logic        sram_oe_n;
  logic        sram_we_n;
  logic [1:0]  sram_bs_n;
  logic [15:0] sram_dq_out;
  logic [15:0] sram_dq_in;
  logic        sram_dq_oe;

  sram_ctl u_sram_ctl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_bs_n(sram_bs_n), .sram_dq_out(sram_dq_out),
    .sram_dq_in(sram_dq_in), .sram_dq_oe(sram_dq_oe)
  );

  typedef struct {
    logic [15:0] data;
    int          due;
    logic [1:0]  be;
  } exp_t;

  exp_t        exp_q[$];
  logic [15:0] mem    [256];
  logic [15:0] shadow [256];
  logic [1:0]  cur_be;
  int checks, failures, cyc, n_reads, n_rsps;
  int viol_bs, viol_cont, viol_oe, viol_dw, viol_wp, viol_rec;
  int we_run, cs_gap;
  bit seen_access, prev_rsp;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] lanes(input logic [15:0] w, input logic [1:0] be);
    return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // RAM model: disabled lanes and idle bus read as A5 so masking is visible
  always_comb begin
    sram_dq_in[15:8] = (!sram_cs_n && !sram_oe_n && !sram_bs_n[1]) ? mem[sram_addr[7:0]][15:8] : 8'hA5;
    sram_dq_in[7:0]  = (!sram_cs_n && !sram_oe_n && !sram_bs_n[0]) ? mem[sram_addr[7:0]][7:0]  : 8'hA5;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (!sram_cs_n && sram_bs_n != ~cur_be) viol_bs++;
      if (sram_dq_oe && !sram_oe_n) viol_cont++;
      if (!sram_we_n && (!sram_oe_n || sram_cs_n)) viol_oe++;
      if (!sram_we_n) begin
        if (!sram_dq_oe) viol_dw++;
        we_run++;
        if (!sram_bs_n[1]) mem[sram_addr[7:0]][15:8] = sram_dq_out[15:8];
        if (!sram_bs_n[0]) mem[sram_addr[7:0]][7:0]  = sram_dq_out[7:0];
      end else begin
        if (we_run != 0 && we_run < WP_EXP) viol_wp++;
        we_run = 0;
      end
      if (sram_cs_n) begin
        cs_gap++;
      end else begin
        if (seen_access && cs_gap > 0 && cs_gap < 2) viol_rec++;
        if (cs_gap > 0) seen_access = 1'b1;
        cs_gap = 0;
      end
    end
  end

  // monitor: scoreboard pop on each response
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        n_rsps++;
        check(!prev_rsp, "R2 rsp pulse width", 32'(prev_rsp), 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected response", 32'(rsp_rdata), 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.be == 2'b11) check(rsp_rdata == e.data, "R2 read data", 32'(rsp_rdata), 32'(e.data));
          else check(rsp_rdata == e.data, "R3 masked read data", 32'(rsp_rdata), 32'(e.data));
          check(cyc == e.due, "R2 read latency", 32'(cyc), 32'(e.due));
        end
      end
      prev_rsp = rsp_valid;
    end
  end

  task automatic do_req(input bit wr, input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
    int acc;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_be    = be;
    req_write = wr;
    req_addr  = {8'h00, a};
    req_wdata = d;
    req_be    = be;
    req_valid = 1'b1;
    acc = cyc + 1;
    if (!wr) begin
      exp_t e;
      e.data = lanes(shadow[a], be);
      e.due  = (be == 2'b00) ? acc : acc + RD_EXP;
      e.be   = be;
      exp_q.push_back(e);
      n_reads++;
    end else begin
      if (be[1]) shadow[a][15:8] = d[15:8];
      if (be[0]) shadow[a][7:0]  = d[7:0];
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R1 ready low after accept", 32'(req_ready), 0);
    if (be == 2'b00) check(sram_cs_n && sram_we_n, "R8 no chip select", 32'({sram_cs_n, sram_we_n}), 3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 16'(i * 16'h0101) ^ 16'h3C00;
      shadow[i] = mem[i];
    end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_be = '0; cur_be = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R1 ready after reset", 32'(req_ready), 1);
    check(sram_cs_n && sram_oe_n && sram_we_n, "R7 strobes high after reset", 32'({sram_cs_n, sram_oe_n, sram_we_n}), 7);
    check(!sram_dq_oe && !rsp_valid, "R5 no drive after reset", 32'({sram_dq_oe, rsp_valid}), 0);

    do_req(0, 8'd5, 16'h0, 2'b11);            // R2 plain read
    do_req(1, 8'd5, 16'hBEEF, 2'b11);         // R4 write right after read (R6 turnaround)
    do_req(0, 8'd5, 16'h0, 2'b11);
    do_req(1, 8'd6, 16'h1234, 2'b10);         // R7 upper lane only
    do_req(0, 8'd6, 16'h0, 2'b11);
    do_req(0, 8'd6, 16'h0, 2'b01);            // R3 lower lane only
    do_req(0, 8'd6, 16'h0, 2'b10);            // R3 upper lane only
    do_req(1, 8'd7, 16'hFFFF, 2'b00);         // R8 zero-enable write
    do_req(0, 8'd7, 16'h0, 2'b11);
    do_req(0, 8'd7, 16'h0, 2'b00);            // R8 zero-enable read
    do_req(1, 8'd8, 16'h00C3, 2'b01);
    do_req(0, 8'd8, 16'h0, 2'b11);
    for (int k = 0; k < 24; k++) begin
      logic [1:0] be;
      be = 2'((k % 3) + 1);
      do_req(1, 8'(16 + k), 16'(k * 16'h1357 + 16'h0A0B), be);
      do_req(0, 8'(16 + k), 16'h0, 2'((k % 4)));
    end
    repeat (8) @(negedge clk);
    check(exp_q.size() == 0, "R2 all reads answered", 32'(exp_q.size()), 0);
    check(n_rsps == n_reads, "R1 one response per read", 32'(n_rsps), 32'(n_reads));
    check(viol_oe == 0, "R4 output enable high during write", 32'(viol_oe), 0);
    check(viol_wp == 0, "R5 write pulse width", 32'(viol_wp), 0);
    check(viol_dw == 0, "R5 data driven during pulse", 32'(viol_dw), 0);
    check(viol_cont == 0, "R6 bus contention", 32'(viol_cont), 0);
    check(viol_bs == 0, "R7 byte strobes", 32'(viol_bs), 0);
    check(viol_rec == 0, "R9 recovery gap", 32'(viol_rec), 0);
    finish_run();
  end

endmodule